// File: doc/BRIEF.md
# Event Interrupt Status Unit with Read-to-Clear

This block gathers twelve event sources from a serial bus controller into one raw status vector. Ten of them are single-cycle pulses that the block latches. The other two are live comparisons of FIFO fill levels against programmable thresholds. A mask register gates the raw vector into a masked status, and the OR of the masked bits drives one interrupt request line.

Software reaches the block through a simple register port with select, write and address inputs. Read data is combinational and valid in the same cycle as the access. Latched events are not cleared by writing ones. Software clears them by reading: one address clears every latched event, and each latched source also has an address of its own. The two level sources follow their inputs directly, so they cannot be cleared.

Top module: `evt_irq_unit`

## Requirements
- R1: Raw status bit positions: 0 receive underflow, 1 receive overflow, 2 receive full, 3 transmit overflow, 4 transmit empty, 5 read request, 6 transmit abort, 7 receive done, 8 activity, 9 stop detected, 10 start detected, 11 general call. Reading address 0x34 returns the raw vector in bits 11:0 and zero in bits 31:12.
- R2: A pulse on `evt_pulse_i` for any latched source (every bit except 2 and 4) sets that raw bit at the next clock edge. The bit then stays set until a clearing read.
- R3: Raw bit 2 is 1 while `rx_level_i` is strictly greater than the receive threshold. Raw bit 4 is 1 while `tx_level_i` is at or below the transmit threshold. Both thresholds are read/write at 0x38 (receive) and 0x3C (transmit), in the low LVL_W bits. Pulses on bits 2 and 4 have no effect.
- R4: The mask is read/write at 0x30 in bits 11:0. Reading 0x2C returns the raw vector ANDed with the mask.
- R5: `irq_o` is 1 exactly when some bit of raw AND mask is 1. With a zero mask, `irq_o` stays 0 while the raw status keeps updating.
- R6: A read of 0x40 clears every latched raw bit at the next edge. Bits 2 and 4 are not affected.
- R7: A read of a per-source clear address clears only that source at the next edge. The addresses are 0x44, 0x48, 0x4C, 0x50, 0x54, 0x58, 0x5C, 0x60, 0x64 and 0x68, in that order, for bits 0, 1, 3, 5, 6, 7, 8, 9, 10 and 11.
- R8: When a pulse arrives in the same cycle as a read that would clear its bit, the bit is set after the edge.
- R9: Reads of clear addresses and of unmapped addresses return all zeros. Writes to the status and clear addresses change no state.
- R10: After reset the latched bits, the mask and both thresholds are zero, and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse_i | input | 12 | Event pulses, one bit per status position |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| tx_level_i | input | LVL_W | Transmit FIFO fill level |
| reg_sel_i | input | 1 | Register access in this cycle |
| reg_wr_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | ADDR_W | Byte address of the access |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, valid in the cycle of a read |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a clearing read that lands in the same cycle as a new pulse for the same bit. The stimulus pairs every per-source clear address, and the combined clear address, with a pulse driven in that exact cycle, and it also uses pulses on other bits. The stimulus also moves the FIFO levels across each threshold while clear reads target the level bits, so the bench can show that those bits never latch.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    localparam int NUM_SRC = 12;

    localparam int SRC_RX_UNDER  = 0;
    localparam int SRC_RX_OVER   = 1;
    localparam int SRC_RX_FULL   = 2;
    localparam int SRC_TX_OVER   = 3;
    localparam int SRC_TX_EMPTY  = 4;
    localparam int SRC_RD_REQ    = 5;
    localparam int SRC_TX_ABORT  = 6;
    localparam int SRC_RX_DONE   = 7;
    localparam int SRC_ACTIVITY  = 8;
    localparam int SRC_STOP_SEEN = 9;
    localparam int SRC_STRT_SEEN = 10;
    localparam int SRC_GEN_CALL  = 11;

    // Bits held in flops; the two level sources are excluded.
    localparam logic [NUM_SRC-1:0] LATCHED_SET =
        ~((NUM_SRC'(1) << SRC_RX_FULL) | (NUM_SRC'(1) << SRC_TX_EMPTY));

    localparam int ADR_MASKED  = 'h2C;
    localparam int ADR_MASK    = 'h30;
    localparam int ADR_RAW     = 'h34;
    localparam int ADR_RX_THR  = 'h38;
    localparam int ADR_TX_THR  = 'h3C;
    localparam int ADR_CLR_ALL = 'h40;
    localparam int ADR_CLR_LO  = 'h44;

    // Clear addresses are packed densely over the latched bits only.
    function automatic int clr_addr_of(input int idx);
        int rank;
        rank = idx;
        if (idx > SRC_RX_FULL)  rank = rank - 1;
        if (idx > SRC_TX_EMPTY) rank = rank - 1;
        return ADR_CLR_LO + 4 * rank;
    endfunction

    localparam int ADR_CLR_HI = ADR_CLR_LO + 4 * (NUM_SRC - 3);

endpackage

// File: rtl/evt_lvl_cmp.sv
module evt_lvl_cmp #(
    parameter int LVL_W = 6
) (
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_thr,
    input  logic [LVL_W-1:0] tx_thr,
    output logic             rx_full,
    output logic             tx_empty
);

    always_comb begin
        rx_full  = (rx_level > rx_thr);
        tx_empty = (tx_level <= tx_thr);
    end

endmodule

// File: rtl/evt_latch_bank.sv
module evt_latch_bank
    import evt_irq_pkg::*;
#(
    parameter int                  N_SRC   = NUM_SRC,
    parameter logic [N_SRC-1:0]    KEEP    = LATCHED_SET
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pulse,
    input  logic [N_SRC-1:0] clr_vec,
    output logic [N_SRC-1:0] lat_q
);

    typedef struct packed {
        logic [N_SRC-1:0] lat;
    } bank_t;

    bank_t             st_d, st_q;
    logic [N_SRC-1:0]  nxt_bit;

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        if (KEEP[i]) begin : g_keep
            // A new pulse takes priority over a clear in the same cycle.
            assign nxt_bit[i] = pulse[i] | (st_q.lat[i] & ~clr_vec[i]);
        end else begin : g_none
            assign nxt_bit[i] = 1'b0;
        end
    end

    always_comb begin
        st_d     = st_q;
        st_d.lat = nxt_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lat_q = st_q.lat;

endmodule

// File: rtl/evt_reg_port.sv
module evt_reg_port
    import evt_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LVL_W  = 6,
    parameter int N_SRC  = NUM_SRC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N_SRC-1:0]  raw_vec,
    output logic [DATA_W-1:0] rdata,
    output logic [N_SRC-1:0]  mask_q,
    output logic [LVL_W-1:0]  rx_thr_q,
    output logic [LVL_W-1:0]  tx_thr_q,
    output logic [N_SRC-1:0]  clr_vec
);

    typedef struct packed {
        logic [N_SRC-1:0] mask;
        logic [LVL_W-1:0] rx_thr;
        logic [LVL_W-1:0] tx_thr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic rd_acc, wr_acc, hit_all;

    assign rd_acc  = sel & ~wr;
    assign wr_acc  = sel & wr;
    assign hit_all = (addr == ADDR_W'(ADR_CLR_ALL));

    for (genvar i = 0; i < N_SRC; i++) begin : g_clr
        if (LATCHED_SET[i]) begin : g_src
            assign clr_vec[i] = rd_acc & (hit_all | (addr == ADDR_W'(clr_addr_of(i))));
        end else begin : g_lvl
            assign clr_vec[i] = 1'b0;
        end
    end

    always_comb begin
        cfg_d = cfg_q;
        if (wr_acc) begin
            if (addr == ADDR_W'(ADR_MASK))   cfg_d.mask   = wdata[N_SRC-1:0];
            if (addr == ADDR_W'(ADR_RX_THR)) cfg_d.rx_thr = wdata[LVL_W-1:0];
            if (addr == ADDR_W'(ADR_TX_THR)) cfg_d.tx_thr = wdata[LVL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata = '0;
        if (rd_acc) begin
            if (addr == ADDR_W'(ADR_MASKED))      rdata = DATA_W'(raw_vec & cfg_q.mask);
            else if (addr == ADDR_W'(ADR_MASK))   rdata = DATA_W'(cfg_q.mask);
            else if (addr == ADDR_W'(ADR_RAW))    rdata = DATA_W'(raw_vec);
            else if (addr == ADDR_W'(ADR_RX_THR)) rdata = DATA_W'(cfg_q.rx_thr);
            else if (addr == ADDR_W'(ADR_TX_THR)) rdata = DATA_W'(cfg_q.tx_thr);
        end
    end

    assign mask_q   = cfg_q.mask;
    assign rx_thr_q = cfg_q.rx_thr;
    assign tx_thr_q = cfg_q.tx_thr;

endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
    import evt_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LVL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       evt_pulse_i,
    input  logic [LVL_W-1:0]  rx_level_i,
    input  logic [LVL_W-1:0]  tx_level_i,
    input  logic              reg_sel_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);

    logic [NUM_SRC-1:0] lat_q, clr_vec, raw_vec, mask_vec;
    logic [LVL_W-1:0]   rx_thr, tx_thr;
    logic               rx_full, tx_empty;

    evt_lvl_cmp #(.LVL_W(LVL_W)) cmp_i (
        .rx_level (rx_level_i),
        .tx_level (tx_level_i),
        .rx_thr   (rx_thr),
        .tx_thr   (tx_thr),
        .rx_full  (rx_full),
        .tx_empty (tx_empty)
    );

    evt_latch_bank #(.N_SRC(NUM_SRC), .KEEP(LATCHED_SET)) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse   (evt_pulse_i),
        .clr_vec (clr_vec),
        .lat_q   (lat_q)
    );

    always_comb begin
        raw_vec               = lat_q;
        raw_vec[SRC_RX_FULL]  = rx_full;
        raw_vec[SRC_TX_EMPTY] = tx_empty;
    end

    evt_reg_port #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LVL_W  (LVL_W),
        .N_SRC  (NUM_SRC)
    ) port_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (reg_sel_i),
        .wr       (reg_wr_i),
        .addr     (reg_addr_i),
        .wdata    (reg_wdata_i),
        .raw_vec  (raw_vec),
        .rdata    (reg_rdata_o),
        .mask_q   (mask_vec),
        .rx_thr_q (rx_thr),
        .tx_thr_q (tx_thr),
        .clr_vec  (clr_vec)
    );

    assign irq_o = |(raw_vec & mask_vec);

endmodule

// File: rtl/evt_irq_unit_chk.sv
module evt_irq_unit_chk
    import evt_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [11:0]       evt_pulse_i,
    input logic              reg_sel_i,
    input logic              reg_wr_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic [DATA_W-1:0] reg_rdata_o,
    input logic              irq_o,
    input logic [11:0]       raw_vec,
    input logic [11:0]       mask_vec
);

    logic [11:0] lp;
    logic        rd, clr_all_rd, clr_range;

    assign lp         = evt_pulse_i & LATCHED_SET;
    assign rd         = reg_sel_i & ~reg_wr_i;
    assign clr_all_rd = rd & (reg_addr_i == ADDR_W'(ADR_CLR_ALL));
    assign clr_range  = (reg_addr_i >= ADDR_W'(ADR_CLR_ALL)) && (reg_addr_i <= ADDR_W'(ADR_CLR_HI));

    assert_pulse_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lp != '0) |=> ((raw_vec & $past(lp)) == $past(lp)));

    assert_mask_zero_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_vec == '0) |-> !irq_o);

    assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all_rd && lp == '0) |=> ((raw_vec & LATCHED_SET) == '0));

    assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && clr_range && lp != '0) |=> ((raw_vec & $past(lp)) == $past(lp)));

    assert_clear_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && clr_range) |-> (reg_rdata_o == '0));

    assert_write_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel_i && reg_wr_i && lp == '0) |=>
            ((raw_vec & LATCHED_SET) == ($past(raw_vec) & LATCHED_SET)));

endmodule

bind evt_irq_unit evt_irq_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_pulse_i (evt_pulse_i),
    .reg_sel_i   (reg_sel_i),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_o       (irq_o),
    .raw_vec     (raw_vec),
    .mask_vec    (mask_vec)
);

// File: tb/evt_irq_unit_tb_top.sv
`timescale 1ns/1ps
module evt_irq_unit_tb_top;

    localparam int LVL_W = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] pulse = '0;
    logic [5:0]  rxl = '0, txl = '0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [11:0] m_lat = '0;
    logic [11:0] m_mask = '0;
    int          m_rxthr = 0, m_txthr = 0;
    int          clr_bits[$] = '{0, 1, 3, 5, 6, 7, 8, 9, 10, 11};

    always #4 clk = ~clk;

    evt_irq_unit #(.ADDR_W(8), .DATA_W(32), .LVL_W(LVL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_pulse_i(pulse),
        .rx_level_i(rxl), .tx_level_i(txl),
        .reg_sel_i(sel), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    function automatic logic [11:0] m_raw();
        logic [11:0] r;
        r = m_lat;
        r[2] = (int'(rxl) > m_rxthr);
        r[4] = (int'(txl) <= m_txthr);
        return r;
    endfunction

    function automatic int clr_index(input logic [7:0] a);
        if (a < 8'h44 || a > 8'h68 || a[1:0] != 2'b00) return -1;
        return (int'(a) - 'h44) / 4;
    endfunction

    function automatic logic [31:0] m_rdata();
        if (!sel || wr) return 32'h0;
        case (addr)
            8'h2C: return {20'h0, m_raw() & m_mask};
            8'h30: return {20'h0, m_mask};
            8'h34: return {20'h0, m_raw()};
            8'h38: return 32'(m_rxthr);
            8'h3C: return 32'(m_txthr);
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare, then advance the model at posedge.
    task automatic step(input string tag, input logic [11:0] p, input logic s,
                        input logic w, input logic [7:0] a, input logic [31:0] d);
        int k;
        @(negedge clk);
        pulse = p; sel = s; wr = w; addr = a; wdata = d;
        #1;
        check({tag, " rdata"}, rdata, m_rdata());
        check({tag, " irq R5"}, {31'h0, irq}, {31'h0, |(m_raw() & m_mask)});
        @(posedge clk);
        if (s && !w) begin
            if (a == 8'h40) m_lat = '0;
            k = clr_index(a);
            if (k >= 0) m_lat[clr_bits[k]] = 1'b0;
        end
        if (s && w) begin
            if (a == 8'h30) m_mask = d[11:0];
            if (a == 8'h38) m_rxthr = int'(d[5:0]);
            if (a == 8'h3C) m_txthr = int'(d[5:0]);
        end
        m_lat = m_lat | (p & 12'hFEB);
    endtask

    task automatic rd(input string tag, input logic [7:0] a);
        step(tag, '0, 1'b1, 1'b0, a, '0);
    endtask

    task automatic wrt(input string tag, input logic [7:0] a, input logic [31:0] d);
        step(tag, '0, 1'b1, 1'b1, a, d);
    endtask

    task automatic idle(input string tag, input logic [11:0] p);
        step(tag, p, 1'b0, 1'b0, '0, '0);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        rd("R10 mask", 8'h30); rd("R10 rxthr", 8'h38); rd("R10 txthr", 8'h3C);
        rd("R10 raw R1", 8'h34);
        // R5: mask zero, events still visible in raw
        idle("R5 pulse", 12'hFFF);
        rd("R5 raw updates", 8'h34);
        rd("R5 masked zero", 8'h2C);
        rd("R6 clear all", 8'h40);
        rd("R6 after", 8'h34);
        // R4 mask
        wrt("R4 mask wr", 8'h30, 32'hFFFF_FFFF);
        rd("R4 mask rd", 8'h30);
        // R1/R2 walk each bit
        for (int i = 0; i < 12; i++) begin
            idle("R2 pulse", 12'(1) << i);
            idle("R2 hold", '0);
            rd("R1 raw", 8'h34);
            rd("R4 masked", 8'h2C);
            rd("R6 clr", 8'h40);
        end
        // R7 per-source clears
        idle("R7 set", 12'hFFF);
        for (int k = 0; k < 10; k++) begin
            rd("R7 clr", 8'(8'h44 + 4 * k));
            rd("R7 raw", 8'h34);
        end
        // R8 pulse in same cycle as clear
        for (int k = 0; k < 10; k++) begin
            idle("R8 set", 12'hFFF);
            step("R8 wins", 12'(1) << clr_bits[k], 1'b1, 1'b0, 8'(8'h44 + 4 * k), '0);
            rd("R8 raw", 8'h34);
        end
        step("R8 all", 12'h801, 1'b1, 1'b0, 8'h40, '0);
        rd("R8 all raw", 8'h34);
        // R3 levels
        wrt("R3 rxthr", 8'h38, 32'd5);
        wrt("R3 txthr", 8'h3C, 32'd3);
        rd("R3 rxthr rd", 8'h38);
        rd("R3 txthr rd", 8'h3C);
        for (int v = 0; v < 8; v++) begin
            @(negedge clk); rxl = 6'(v); txl = 6'(v);
            rd("R3 raw", 8'h34);
            rd("R3 clr lvl", 8'h40);
            idle("R3 pulse ignored", 12'h014);
            rd("R3 raw2", 8'h34);
        end
        @(negedge clk); rxl = 6'd63; txl = 6'd63;
        wrt("R3 rx max", 8'h38, 32'd63);
        wrt("R3 tx max", 8'h3C, 32'd63);
        rd("R3 edge", 8'h34);
        // R9 writes and unmapped reads
        idle("R9 set", 12'h0F0);
        wrt("R9 wr raw", 8'h34, 32'h0);
        wrt("R9 wr clr", 8'h40, 32'h0);
        wrt("R9 wr masked", 8'h2C, 32'h0);
        rd("R9 raw kept", 8'h34);
        rd("R9 unmapped", 8'h00);
        rd("R9 unmapped2", 8'hFC);
        rd("R9 clr zero", 8'h5C);
        // R5 mask zero with live events
        wrt("R5 mask off", 8'h30, 32'h0);
        idle("R5 events", 12'hAAA);
        rd("R5 raw", 8'h34);
        wrt("R5 one bit", 8'h30, 32'h200);
        rd("R5 masked", 8'h2C);
        idle("R5 end", '0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule